// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands at a selectable byte or word width and derives six status flags from the result: carry (borrow on subtract), parity, auxiliary (low-nibble) carry, zero, sign and signed overflow. The result and flags are produced combinationally in the same cycle as the operands, so a datapath can use them at once.

A flag register beside the arithmetic captures the six arithmetic flags on an update strobe. It also holds three control bits (single-step trap, interrupt enable, string direction). These bits change only through their own load strobe, so arithmetic never disturbs them. An execution unit drives the operands, sets the strobe on instructions that write flags, and reads back the stored flags for the next add-with-carry or conditional step.

Top module: `arith_flag_gen`

## Requirements
- R1: `op_sel` selects 0 = add, 1 = add-with-carry, 2 = subtract, 3 = subtract-with-borrow. `result` is the low 8 bits of the outcome when `word_mode`=0, with bits 15:8 forced to zero. It is the low 16 bits when `word_mode`=1. In byte mode, operand bits 15:8 are ignored.
- R2: Carry, `live_flags[0]`, is the unsigned carry out of the selected width on add. On subtract it is set when the unsigned minuend is less than the subtrahend plus borrow-in. For example, byte 255 + 1 sets it.
- R3: Auxiliary, `live_flags[2]`, is the carry out of bit 3 into bit 4 on add. On subtract it is the borrow from bit 4.
- R4: Zero, `live_flags[3]`, is 1 exactly when `result` at the selected width is zero.
- R5: Sign, `live_flags[4]`, equals bit 7 of the result in byte mode and bit 15 in word mode.
- R6: Parity, `live_flags[1]`, is 1 when the low 8 bits of the result hold an even number of ones. This holds in word mode as well.
- R7: Overflow, `live_flags[5]`, is set on signed overflow. On add, both operands share a sign that the result lacks; for example, byte 100 + 50 sets it. On subtract, the operand signs differ and the result sign differs from the minuend.
- R8: On a rising clock edge with `upd_en`=1, `flags_q[5:0]` loads `live_flags`. Otherwise it holds. Reset clears all nine bits of `flags_q`.
- R9: `flags_q[6]` (trap), `flags_q[7]` (interrupt enable) and `flags_q[8]` (direction) load `ctl_val[0]`, `ctl_val[1]` and `ctl_val[2]` on an edge with `ctl_load`=1. Arithmetic and `upd_en` never change them.
- R10: `carry_in` affects only the add-with-carry and subtract-with-borrow operations. Plain add and subtract ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (minuend on subtract) |
| op_b | input | 16 | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Carry or borrow input |
| op_sel | input | 2 | Operation code |
| word_mode | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| upd_en | input | 1 | Capture arithmetic flags into the register |
| ctl_load | input | 1 | Load the three control bits |
| ctl_val | input | 3 | Values for the control bits |
| result | output | 16 | Arithmetic result |
| live_flags | output | 6 | Combinational flags {of,sf,zf,af,pf,cf} |
| flags_q | output | 9 | Registered {df,ie,tf,of,sf,zf,af,pf,cf} |

## Verification
The bench hits byte 255 + 1 and byte 100 + 50. A design that took carry or overflow from the word width would miss both flags. Word-mode results with an odd-ones high byte expose parity taken over the full word. Subtract-with-borrow at a nibble edge catches a borrow computed as a carry, which flips carry and auxiliary. The bench also checks that plain add ignores `carry_in`, and that an arithmetic update with odd control-looking bits leaves trap, interrupt and direction untouched. A register that loaded every cycle or shared one strobe would fail there.

// File: rtl/afg_pkg.sv
package afg_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_ADC = 2'd1,
      OP_SUB = 2'd2,
      OP_SBB = 2'd3
   } afg_op_e;

   localparam int FL_CF = 0;
   localparam int FL_PF = 1;
   localparam int FL_AF = 2;
   localparam int FL_ZF = 3;
   localparam int FL_SF = 4;
   localparam int FL_OF = 5;
   localparam int ARITH_FLAGS = 6;
   localparam int CTL_FLAGS   = 3;
endpackage

// File: rtl/afg_addsub.sv
module afg_addsub
   import afg_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [WIDE_W-1:0] a,
   input  logic [WIDE_W-1:0] b,
   input  logic              cin,
   input  afg_op_e           op,
   input  logic              word,
   output logic [WIDE_W-1:0] res,
   output logic              carry,
   output logic              aux
);
   localparam logic [WIDE_W-1:0] NARROW_MASK = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [WIDE_W-1:0] mask, am, bm;
   logic [WIDE_W:0]   full;
   logic [4:0]        nib;
   logic              ci, is_sub;

   always_comb begin
      mask   = word ? {WIDE_W{1'b1}} : NARROW_MASK;
      am     = a & mask;
      bm     = b & mask;
      ci     = (op == OP_ADC || op == OP_SBB) ? cin : 1'b0;
      is_sub = (op == OP_SUB || op == OP_SBB);
      if (is_sub) begin
         full = {1'b0, am} - {1'b0, bm} - {{WIDE_W{1'b0}}, ci};
         nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, ci};
      end else begin
         full = {1'b0, am} + {1'b0, bm} + {{WIDE_W{1'b0}}, ci};
         nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, ci};
      end
      res   = full[WIDE_W-1:0] & mask;
      carry = word ? full[WIDE_W] : full[NARROW_W];
      aux   = nib[4];
   end
endmodule

// File: rtl/afg_flag_eval.sv
module afg_flag_eval #(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PAR_W    = 8
) (
   input  logic [WIDE_W-1:0] res,
   input  logic              word,
   input  logic              is_sub,
   input  logic              a_sgn,
   input  logic              b_sgn,
   output logic              zf,
   output logic              sf,
   output logic              pf,
   output logic              of
);
   logic [PAR_W-1:0] par_chain;

   generate
      genvar gi;
      for (gi = 0; gi < PAR_W; gi++) begin : g_par
         if (gi == 0) begin : g_first
            assign par_chain[gi] = ~res[gi];
         end else begin : g_next
            assign par_chain[gi] = par_chain[gi-1] ^ res[gi];
         end
      end
   endgenerate

   always_comb begin
      zf = (res == '0);
      sf = word ? res[WIDE_W-1] : res[NARROW_W-1];
      pf = par_chain[PAR_W-1];
      if (is_sub) of = (a_sgn != b_sgn) && (sf != a_sgn);
      else        of = (a_sgn == b_sgn) && (sf != a_sgn);
   end

   // R5 / R4: a zero result cannot carry a set sign bit
   always_comb begin
      assert_zero_not_neg_R4: assert (!(zf && sf));
   end
endmodule

// File: rtl/afg_flag_reg.sv
module afg_flag_reg
   import afg_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd_en,
   input  logic                   ctl_load,
   input  logic [ARITH_FLAGS-1:0] arith_in,
   input  logic [CTL_FLAGS-1:0]   ctl_in,
   output logic [ARITH_FLAGS+CTL_FLAGS-1:0] q
);
   logic [ARITH_FLAGS-1:0] ar_q;
   logic [CTL_FLAGS-1:0]   ct_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_q <= '0;
         ct_q <= '0;
      end else begin
         if (upd_en)   ar_q <= arith_in;
         if (ctl_load) ct_q <= ctl_in;
      end
   end

   assign q = {ct_q, ar_q};

   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(q[ARITH_FLAGS-1:0]));
   assert_flag_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> q[ARITH_FLAGS-1:0] == $past(arith_in));
   assert_ctl_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_load |=> $stable(q[ARITH_FLAGS+CTL_FLAGS-1:ARITH_FLAGS]));
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen
   import afg_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PAR_W    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [WIDE_W-1:0]     op_a,
   input  logic [WIDE_W-1:0]     op_b,
   input  logic                  carry_in,
   input  logic [1:0]            op_sel,
   input  logic                  word_mode,
   input  logic                  upd_en,
   input  logic                  ctl_load,
   input  logic [CTL_FLAGS-1:0]  ctl_val,
   output logic [WIDE_W-1:0]     result,
   output logic [ARITH_FLAGS-1:0] live_flags,
   output logic [ARITH_FLAGS+CTL_FLAGS-1:0] flags_q
);
   generate
      if (WIDE_W != 2 * NARROW_W) begin : g_bad_w
         $error("WIDE_W must be twice NARROW_W");
      end
      if (PAR_W > NARROW_W || NARROW_W < 5) begin : g_bad_p
         $error("PAR_W must fit in NARROW_W, NARROW_W at least 5");
      end
   endgenerate

   afg_op_e op;
   logic    carry, aux, zf, sf, pf, of, a_sgn, b_sgn, is_sub;

   assign op     = afg_op_e'(op_sel);
   assign is_sub = op_sel[1];
   assign a_sgn  = word_mode ? op_a[WIDE_W-1] : op_a[NARROW_W-1];
   assign b_sgn  = word_mode ? op_b[WIDE_W-1] : op_b[NARROW_W-1];

   afg_addsub #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_core (
      .a(op_a), .b(op_b), .cin(carry_in), .op(op), .word(word_mode),
      .res(result), .carry(carry), .aux(aux));

   afg_flag_eval #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .PAR_W(PAR_W)) u_eval (
      .res(result), .word(word_mode), .is_sub(is_sub), .a_sgn(a_sgn), .b_sgn(b_sgn),
      .zf(zf), .sf(sf), .pf(pf), .of(of));

   always_comb begin
      live_flags        = '0;
      live_flags[FL_CF] = carry;
      live_flags[FL_PF] = pf;
      live_flags[FL_AF] = aux;
      live_flags[FL_ZF] = zf;
      live_flags[FL_SF] = sf;
      live_flags[FL_OF] = of;
   end

   afg_flag_reg u_reg (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .ctl_load(ctl_load),
      .arith_in(live_flags), .ctl_in(ctl_val), .q(flags_q));

   assert_byte_upper_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !word_mode |-> result[WIDE_W-1:NARROW_W] == '0);
   assert_add_no_carry_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_sub && !word_mode && !live_flags[FL_CF]) |->
      result[NARROW_W-1:0] >= op_a[NARROW_W-1:0]);
endmodule

// File: tb/sim_arith_flag_gen.sv
module sim_arith_flag_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        carry_in = 1'b0;
   logic [1:0]  op_sel = '0;
   logic        word_mode = 1'b0, upd_en = 1'b0, ctl_load = 1'b0;
   logic [2:0]  ctl_val = '0;
   logic [15:0] result;
   logic [5:0]  live_flags;
   logic [8:0]  flags_q;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   arith_flag_gen u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .op_sel(op_sel), .word_mode(word_mode), .upd_en(upd_en),
      .ctl_load(ctl_load), .ctl_val(ctl_val), .result(result),
      .live_flags(live_flags), .flags_q(flags_q));

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // expected model from the requirements
   task automatic model(input logic [15:0] a, input logic [15:0] b, input logic ci,
                        input logic [1:0] op, input logic w,
                        output logic [15:0] r, output logic [5:0] f);
      int mask, am, bm, c, full, sb;
      mask = w ? 16'hFFFF : 16'h00FF;
      sb   = w ? 15 : 7;
      am = int'(a) & mask; bm = int'(b) & mask;
      c  = op[0] ? int'(ci) : 0;
      f  = '0;
      if (!op[1]) begin
         full = am + bm + c;
         f[0] = full > mask;
         f[2] = ((am & 15) + (bm & 15) + c) > 15;
      end else begin
         full = am - bm - c;
         f[0] = am < (bm + c);
         f[2] = (am & 15) < ((bm & 15) + c);
      end
      r = 16'(full & mask);
      f[3] = (r == 0);
      f[4] = r[sb];
      f[1] = ($countones(r[7:0]) % 2) == 0;
      if (!op[1]) f[5] = (am[sb] == bm[sb]) && (r[sb] != am[sb]);
      else        f[5] = (am[sb] != bm[sb]) && (r[sb] != am[sb]);
   endtask

   task automatic run_op(string req, logic [15:0] a, logic [15:0] b, logic ci,
                         logic [1:0] op, logic w);
      logic [15:0] er; logic [5:0] ef; logic [2:0] ctl_before;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci; op_sel = op; word_mode = w; upd_en = 1'b1;
      ctl_before = flags_q[8:6];
      model(a, b, ci, op, w, er, ef);
      #1;
      chk({req, " result"}, 32'(result), 32'(er));
      chk({req, " flags"}, 32'(live_flags), 32'(ef));
      @(negedge clk);
      upd_en = 1'b0;
      chk({req, " R8 reg"}, 32'(flags_q[5:0]), 32'(ef));
      chk({req, " R9 ctl"}, 32'(flags_q[8:6]), 32'(ctl_before));
   endtask

   task automatic t_reset;
      chk("R8 reset", 32'(flags_q), 32'h0);
   endtask

   task automatic t_named;
      run_op("R2 255+1", 16'h00FF, 16'h0001, 1'b0, 2'd0, 1'b0);
      chk("R2 carry 255+1", 32'(flags_q[0]), 32'h1);
      chk("R4 zero 255+1", 32'(flags_q[3]), 32'h1);
      run_op("R7 100+50", 16'd100, 16'd50, 1'b0, 2'd0, 1'b0);
      chk("R7 of 100+50", 32'(flags_q[5]), 32'h1);
      chk("R5 sign 100+50", 32'(flags_q[4]), 32'h1);
   endtask

   task automatic t_sub;
      run_op("R2 sub borrow", 16'h0010, 16'h0020, 1'b0, 2'd2, 1'b0);
      run_op("R3 sbb nibble", 16'h0010, 16'h0000, 1'b1, 2'd3, 1'b0);
      chk("R3 aux borrow", 32'(flags_q[2]), 32'h1);
      run_op("R7 sub of", 16'h0080, 16'h0001, 1'b0, 2'd2, 1'b0);
      run_op("R7 word sub", 16'h8000, 16'h0001, 1'b0, 2'd2, 1'b1);
   endtask

   task automatic t_word;
      run_op("R1 word adc", 16'h12F8, 16'h0F0F, 1'b1, 2'd1, 1'b1);
      run_op("R6 word parity", 16'h0100, 16'h0003, 1'b0, 2'd0, 1'b1);
      chk("R6 low byte only", 32'(flags_q[1]), 32'h1);
      run_op("R1 byte ignores high", 16'hAB05, 16'hCD03, 1'b0, 2'd0, 1'b0);
      run_op("R5 word sign", 16'h7FFF, 16'h0001, 1'b0, 2'd0, 1'b1);
   endtask

   task automatic t_cin_ignored;
      run_op("R10 add cin", 16'h000F, 16'h0001, 1'b1, 2'd0, 1'b0);
      chk("R10 add result", 32'(result), 32'h10);
      run_op("R10 sub cin", 16'h0005, 16'h0005, 1'b1, 2'd2, 1'b0);
      chk("R10 sub zero", 32'(flags_q[3]), 32'h1);
   endtask

   task automatic t_hold_ctl;
      logic [5:0] kept;
      kept = flags_q[5:0];
      @(negedge clk);
      op_a = 16'h00FF; op_b = 16'h00FF; op_sel = 2'd0; word_mode = 1'b0; upd_en = 1'b0;
      @(negedge clk);
      chk("R8 hold", 32'(flags_q[5:0]), 32'(kept));
      ctl_val = 3'b101; ctl_load = 1'b1;
      @(negedge clk);
      ctl_load = 1'b0;
      chk("R9 ctl load", 32'(flags_q[8:6]), 32'h5);
      chk("R9 arith kept", 32'(flags_q[5:0]), 32'(kept));
      ctl_val = 3'b010;
      run_op("R9 arith after ctl", 16'h0001, 16'h0001, 1'b0, 2'd0, 1'b0);
      chk("R9 ctl stays", 32'(flags_q[8:6]), 32'h5);
   endtask

   initial begin
      #50000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #5;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_named();
      t_sub();
      t_word();
      t_cin_ignored();
      t_hold_ctl();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule